// File: doc/BRIEF.md
# De-skew Training Sequence Transmitter

This block produces the word stream for the transmit side of a 16-bit source-synchronous link, where each word comes with a control flag, a parity bit and a protocol-phase flag. Each clock it chooses one of three sources. The first is a de-skew training sequence, which the far-end receiver uses to realign its lanes. The second is a frame word offered by an upstream producer through a valid/ready handshake. The third is filler, which alternates between an Idle word and a Dead word.

A training sequence is a fixed 20-word pattern repeated a programmable number of times. Training starts for either of two reasons. One is a request pulse from the local receive side, raised when that side sees its peer asking for training. The other is backpressure that has been held for 32 consecutive clocks while dynamic de-skew is enabled. Training takes priority over everything else, and once it has started it always runs to the end. A request that arrives while training is under way is stored and is served immediately after the current sequence. A frame that has already started is completed before training begins, unless the force input is asserted.

Top module: `deskew_train_tx`

## Requirements
- R1: While `rst_n` is low, `tx_data`, `tx_ctl`, `tx_par` and `tx_prot` are all 0.
- R2: Each training pattern is 20 words. Words 0 to 9 are `tx_data`=0x0FFF with `tx_ctl`=1, `tx_par`=1 and `tx_prot`=0. Words 10 to 19 are `tx_data`=0xF000 with `tx_ctl`=0, `tx_par`=0 and `tx_prot`=1.
- R3: A training sequence sends `alpha` patterns back to back, which is `alpha`×20 consecutive training words. No control or filler word is inserted before the first training word.
- R4: An `alpha` of 0 is treated as 1. `alpha` is sampled when a sequence starts, so a later change does not alter that sequence.
- R5: A `train_req` pulse that is sampled while no training is running and no frame is open puts the first training word on the outputs at that same clock edge.
- R6: A request that arrives during training is stored. A new sequence follows on the edge right after the last word of the current one. Training is never shortened.
- R7: With `deskew_en`=1, a `bp` input that is high on 32 consecutive sampled edges starts training at the 32nd edge. The count restarts when `bp` or `deskew_en` is low, when the count triggers, and when any training sequence starts.
- R8: Training outranks frame words, and frame words outrank filler. `frm_ready` is high exactly when a frame word offered in that cycle would be sent at the next edge.
- R9: After a frame word with `frm_last`=0 has been sent, training does not start until a word with `frm_last`=1 has been sent. A high `force_train` overrides this rule.
- R10: When there is nothing else to send, the outputs alternate between Idle (0x0000, `tx_ctl`=1) and Dead (0xFF3F, `tx_ctl`=0), starting with Idle after reset. In both filler words the ready bits [7:6] are 0 and `tx_prot` is 0.
- R11: An accepted frame word appears on the outputs at the next edge with its data and control flag unchanged. `tx_par` is the XOR of the 16 data bits and `tx_prot` is 0. Filler words use the same parity rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| deskew_en | input | 1 | Enables the backpressure-triggered training |
| alpha | input | 4 | Number of patterns in a training sequence |
| train_req | input | 1 | Training request pulse from the receive side |
| bp | input | 1 | Backpressure level from the far end |
| force_train | input | 1 | Lets a pending training sequence cut into an open frame |
| frm_valid | input | 1 | Upstream frame word is valid |
| frm_data | input | 16 | Upstream frame word data |
| frm_ctl | input | 1 | Upstream control flag for the word |
| frm_last | input | 1 | Marks the final word of a frame |
| frm_ready | output | 1 | Frame word will be taken at the next edge |
| tx_data | output | 16 | Link data word |
| tx_ctl | output | 1 | Link control flag |
| tx_par | output | 1 | Link parity bit |
| tx_prot | output | 1 | Link protocol-phase flag |

## Verification
The assertions check the following on every clock:
- every training word carries one of the two legal pattern encodings;
- a sequence that is still running continues on the next edge;
- a pending request with no open frame starts training at the next edge;
- an open frame holds training off unless force is asserted;
- a backpressure trigger is either served or stored;
- consecutive filler words differ and keep their ready bits clear.

Some behaviour can only be shown by the bench's scenarios. These cover the exact number of words for several `alpha` values, including the zero case, and the sampling of `alpha` at the start of a sequence. They also cover the back-to-back sequence produced by a request stored during training, the exact edge at which 32 cycles of backpressure trigger, and the restart of that count after a gap.

// File: rtl/deskew_train_tx.sv
module deskew_train_tx #(
  parameter int DW = 16,
  parameter int AW = 4,
  parameter int HALF = 10,
  parameter int BP_LIMIT = 32,
  parameter logic [DW-1:0] PAT_A = DW'(16'h0FFF),
  parameter logic [DW-1:0] PAT_B = DW'(16'hF000),
  parameter logic [DW-1:0] IDLE_WORD = DW'(16'h0000),
  parameter logic [DW-1:0] DEAD_WORD = DW'(16'hFF3F)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          deskew_en,
  input  logic [AW-1:0] alpha,
  input  logic          train_req,
  input  logic          bp,
  input  logic          force_train,
  input  logic          frm_valid,
  input  logic [DW-1:0] frm_data,
  input  logic          frm_ctl,
  input  logic          frm_last,
  output logic          frm_ready,
  output logic [DW-1:0] tx_data,
  output logic          tx_ctl,
  output logic          tx_par,
  output logic          tx_prot
);
  localparam int PAT_LEN = 2 * HALF;
  localparam int WCW = $clog2(PAT_LEN);
  localparam int BPW = $clog2(BP_LIMIT);

  logic [WCW-1:0] tr_word, nxt_word;
  logic [AW-1:0]  tr_rep, tr_alpha, alpha_eff;
  logic [BPW-1:0] bp_cnt;
  logic tr_act, pend, in_frame, fill_odd, fill_act;
  logic tr_last, tr_busy, bp_hit, req_any, start_tr, take_frm, take_fill, wrap;
  logic [DW-1:0] fill_word;

  assign alpha_eff = (alpha == '0) ? AW'(1) : alpha;
  assign wrap      = tr_word == WCW'(PAT_LEN - 1);
  assign tr_last   = wrap && (tr_rep == tr_alpha - 1'b1);
  assign tr_busy   = tr_act && !tr_last;
  assign bp_hit    = deskew_en && bp && (bp_cnt == BPW'(BP_LIMIT - 1));
  assign req_any   = pend || train_req || bp_hit;
  assign start_tr  = !tr_busy && req_any && (!in_frame || force_train);
  assign frm_ready = !tr_busy && !start_tr;
  assign take_frm  = frm_ready && frm_valid;
  assign take_fill = frm_ready && !frm_valid;
  assign nxt_word  = (start_tr || wrap) ? '0 : tr_word + 1'b1;
  assign fill_word = fill_odd ? DEAD_WORD : IDLE_WORD;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tr_act   <= 1'b0;
      tr_word  <= '0;
      tr_rep   <= '0;
      tr_alpha <= AW'(1);
      pend     <= 1'b0;
      bp_cnt   <= '0;
      in_frame <= 1'b0;
      fill_odd <= 1'b0;
      fill_act <= 1'b0;
    end else begin
      pend   <= req_any && !start_tr;
      bp_cnt <= (!(deskew_en && bp) || bp_hit || start_tr) ? '0 : bp_cnt + 1'b1;
      if (start_tr) begin
        tr_act   <= 1'b1;
        tr_word  <= '0;
        tr_rep   <= '0;
        tr_alpha <= alpha_eff;
        in_frame <= 1'b0;
      end else if (tr_busy) begin
        tr_word <= nxt_word;
        if (wrap) tr_rep <= tr_rep + 1'b1;
      end else begin
        tr_act <= 1'b0;
      end
      if (take_frm) in_frame <= !frm_last;
      fill_act <= take_fill;
      if (take_fill) fill_odd <= !fill_odd;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_data <= '0;
      tx_ctl  <= 1'b0;
      tx_par  <= 1'b0;
      tx_prot <= 1'b0;
    end else if (start_tr || tr_busy) begin
      tx_data <= (nxt_word < WCW'(HALF)) ? PAT_A : PAT_B;
      tx_ctl  <= nxt_word < WCW'(HALF);
      tx_par  <= nxt_word < WCW'(HALF);
      tx_prot <= !(nxt_word < WCW'(HALF));
    end else if (take_frm) begin
      tx_data <= frm_data;
      tx_ctl  <= frm_ctl;
      tx_par  <= ^frm_data;
      tx_prot <= 1'b0;
    end else begin
      tx_data <= fill_word;
      tx_ctl  <= !fill_odd;
      tx_par  <= ^fill_word;
      tx_prot <= 1'b0;
    end
  end

  // R2
  train_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tr_act |-> ((tx_data == PAT_A && tx_ctl && tx_par && !tx_prot) ||
                (tx_data == PAT_B && !tx_ctl && !tx_par && tx_prot)));

  // R6
  no_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tr_busy |=> tr_act);

  // R8
  pend_serve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !tr_busy && !in_frame) |=> tr_act);

  // R9
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_frame && !force_train && !tr_act) |=> !tr_act);

  // R7
  bp_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bp_hit |=> (tr_act || pend));

  // R10
  fill_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_act && $past(fill_act)) |-> tx_data != $past(tx_data));

  // R10
  ready_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_act |-> (tx_data[7:6] == 2'b00 && !tx_prot));
endmodule

// File: tb/deskew_train_tx_bench.sv
module deskew_train_tx_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic deskew_en = 0, train_req = 0, bp = 0, force_train = 0;
  logic [3:0] alpha = 4'd1;
  logic frm_valid = 0, frm_ctl = 0, frm_last = 0;
  logic [15:0] frm_data = '0;
  logic frm_ready, tx_ctl, tx_par, tx_prot;
  logic [15:0] tx_data;

  int checks = 0, failures = 0, cyc = 0, tr_seen = 0;
  bit done = 0;

  always #2 clk = ~clk;

  deskew_train_tx u_deskew_train_tx (
    .clk(clk), .rst_n(rst_n), .deskew_en(deskew_en), .alpha(alpha),
    .train_req(train_req), .bp(bp), .force_train(force_train),
    .frm_valid(frm_valid), .frm_data(frm_data), .frm_ctl(frm_ctl),
    .frm_last(frm_last), .frm_ready(frm_ready), .tx_data(tx_data),
    .tx_ctl(tx_ctl), .tx_par(tx_par), .tx_prot(tx_prot));

  // reference model state: {prot, par, ctl, data}
  logic [18:0] q[$];
  logic [18:0] exp_w = '0;
  int exp_kind = 2;
  bit m_pend = 0, m_inframe = 0, m_phase = 0;
  int m_bp = 0;

  function automatic bit m_bphit();
    return deskew_en && bp && (m_bp == 31);
  endfunction
  function automatic bit m_start();
    return (q.size() == 0) && (m_pend || train_req || m_bphit()) && (!m_inframe || force_train);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic model_edge();
    bit hit, st, req;
    hit = m_bphit();
    st  = m_start();
    req = m_pend || train_req || hit;
    if (q.size() > 0) begin
      exp_w = q.pop_front(); exp_kind = 0;
    end else if (st) begin
      int a;
      a = (alpha == 0) ? 1 : int'(alpha);
      for (int r = 0; r < a; r++)
        for (int k = 0; k < 20; k++)
          q.push_back(k < 10 ? {1'b0, 1'b1, 1'b1, 16'h0FFF} : {1'b1, 1'b0, 1'b0, 16'hF000});
      exp_w = q.pop_front(); exp_kind = 0;
      m_inframe = 0;
    end else if (frm_valid) begin
      exp_w = {1'b0, ^frm_data, frm_ctl, frm_data}; exp_kind = 1;
      m_inframe = !frm_last;
    end else begin
      exp_w = m_phase ? {1'b0, ^16'hFF3F, 1'b0, 16'hFF3F} : {1'b0, 1'b0, 1'b1, 16'h0000};
      exp_kind = 2;
      m_phase = !m_phase;
    end
    m_pend = req && !st;
    if (!(deskew_en && bp) || hit || st) m_bp = 0; else m_bp++;
  endtask

  task automatic tick();
    logic [18:0] got;
    #1;
    if (rst_n) chk(frm_ready == !((q.size() > 0) || m_start()), "R8 frm_ready", frm_ready, !((q.size() > 0) || m_start()));
    @(posedge clk);
    if (rst_n) model_edge();
    @(negedge clk);
    got = {tx_prot, tx_par, tx_ctl, tx_data};
    if (!rst_n)
      chk(got == '0, "R1 reset outputs", got, 0);
    else
      chk(got == exp_w, exp_kind == 0 ? "R2 training word" : (exp_kind == 1 ? "R11 frame word" : "R10 filler word"), got, exp_w);
    if ((tx_data == 16'h0FFF && tx_ctl && tx_par) || (tx_data == 16'hF000 && tx_prot)) tr_seen++;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic req_pulse();
    train_req = 1; tick(); train_req = 0;
  endtask

  task automatic fword(input logic [15:0] d, input bit c, input bit l);
    frm_valid = 1; frm_data = d; frm_ctl = c; frm_last = l;
    tick();
    frm_valid = 0; frm_last = 0; frm_ctl = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    ticks(3);                                   // R1
    rst_n = 1;
    tick();
    chk(tx_data == 16'h0000 && tx_ctl, "R10 first filler is Idle", tx_data, 16'h0000);
    ticks(5);

    for (int i = 0; i < 4; i++) fword(16'h1230 + 16'(i), i == 0, i == 3);  // R11
    ticks(2);

    // R5 / R3: alpha = 2
    alpha = 4'd2; tr_seen = 0;
    req_pulse();
    chk(tx_data == 16'h0FFF && tx_ctl && tx_par && !tx_prot, "R5 first word after request", tx_data, 16'h0FFF);
    ticks(45);
    chk(tr_seen == 40, "R3 sequence length alpha=2", tr_seen, 40);

    // R6 / R4: stored request, alpha sampled at start
    alpha = 4'd3; tr_seen = 0;
    req_pulse();
    ticks(4);
    alpha = 4'd0;
    req_pulse();
    ticks(54);
    chk(tx_data == 16'hF000 && tx_prot, "R6 end of first sequence", tx_data, 16'hF000);
    tick();
    chk(tx_data == 16'h0FFF && tx_ctl, "R6 stored request follows at once", tx_data, 16'h0FFF);
    ticks(25);
    chk(tr_seen == 80, "R6 total words of both sequences", tr_seen, 80);

    // R4: alpha zero alone
    tr_seen = 0; alpha = 4'd0;
    req_pulse(); ticks(25);
    chk(tr_seen == 20, "R4 alpha zero acts as one", tr_seen, 20);

    // R9: open frame defers training
    alpha = 4'd1; tr_seen = 0;
    fword(16'h5500, 1, 0); fword(16'h5501, 0, 0);
    req_pulse(); ticks(3);
    chk(tr_seen == 0, "R9 training held during open frame", tr_seen, 0);
    fword(16'h5502, 0, 1);
    tick();
    chk(tx_data == 16'h0FFF, "R9 training after frame end", tx_data, 16'h0FFF);
    ticks(22);
    chk(tr_seen == 20, "R9 deferred sequence length", tr_seen, 20);

    // R9: force cuts into an open frame
    tr_seen = 0;
    fword(16'h6600, 1, 0);
    force_train = 1; req_pulse(); force_train = 0;
    chk(tr_seen == 1, "R9 force starts training in open frame", tr_seen, 1);
    ticks(22);
    fword(16'h6601, 0, 1);
    ticks(2);

    // R7: 32 cycles of backpressure
    deskew_en = 1; tr_seen = 0; bp = 1;
    ticks(31);
    chk(tr_seen == 0, "R7 no trigger before 32 edges", tr_seen, 0);
    tick();
    chk(tx_data == 16'h0FFF && tx_ctl, "R7 trigger at 32nd edge", tx_data, 16'h0FFF);
    bp = 0; ticks(22);
    chk(tr_seen == 20, "R7 triggered sequence length", tr_seen, 20);

    // R7: a gap restarts the count
    tr_seen = 0; bp = 1; ticks(20); bp = 0; tick(); bp = 1; ticks(31); bp = 0;
    chk(tr_seen == 0, "R7 gap restarts count", tr_seen, 0);
    ticks(3);

    // R7: disabled de-skew ignores backpressure
    deskew_en = 0; bp = 1; ticks(40); bp = 0;
    chk(tr_seen == 0, "R7 disabled de-skew ignores bp", tr_seen, 0);

    // R8: training outranks a waiting frame stream
    tr_seen = 0;
    frm_valid = 1; frm_data = 16'h7700; frm_ctl = 1; frm_last = 1;
    train_req = 1; tick(); train_req = 0;
    chk(tx_data == 16'h0FFF, "R8 training beats frame word", tx_data, 16'h0FFF);
    ticks(20);
    chk(tx_data == 16'h7700 && tx_ctl, "R8 frame resumes after training", tx_data, 16'h7700);
    frm_valid = 0; frm_last = 0; frm_ctl = 0;
    ticks(4);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule